// File: doc/BRIEF.md
# SPI Buffered Status and Interrupt Controller

This block tracks the state of a serial port whose transmit and receive paths each have a small FIFO. The FIFOs and the serial shifter sit outside the block. Each cycle they report the two FIFO fill levels, a strobe when the shifter takes a word, and a strobe when a word has finished shifting. From these the block keeps a shifter busy/idle state machine and a status word. The status word holds an element count, shifter-empty, receive-empty, transmit-full, receive-full, and a receive-overflow flag that hardware sets and software clears. The block also says whether an arriving word may be pushed into the receive FIFO.

A 3-bit mode field picks one of eight conditions. Four are on the transmit side and four on the receive side. A rising edge of the selected condition produces a one-cycle interrupt request on the following cycle. When the enable input is low the block is disabled: the shifter is held idle, the overflow flag is cleared, and every status output and the interrupt read 0.

The shifter state machine has two states. `SH_IDLE` is the ready state and the reset state. `SH_BUSY` means a word is in the shifter. The transition IDLE→BUSY happens when `shift_start` arrives while the transmit FIFO holds at least one word. The transition BUSY→IDLE happens on `shift_done`. Dropping `en` forces IDLE from either state.

Top module: `spi_buf_status_irq`

## Requirements
- R1: `sr_empty` is 1 while enabled and the shifter is idle. `shift_start` with `tx_level` nonzero moves the shifter to busy, which drops `sr_empty` after the edge. `shift_start` with `tx_level` = 0 is ignored. `shift_done` while busy returns it to idle.
- R2: While enabled, `rx_empty` is 1 exactly when `rx_level` = 0, `tx_full` exactly when `tx_level` = DEPTH (8), and `rx_full` exactly when `rx_level` = DEPTH.
- R3: `elem_cnt` is the number of pending transfers when `master` = 1: `tx_level` plus 1 if the shifter is busy. It is the number of unread words (`rx_level`) when `master` = 0. In both cases it saturates at 7.
- R4: If `shift_done` arrives while busy and `rx_level` = DEPTH, the word is dropped (`rx_accept` stays 0) and `rx_ovf` is 1 after the edge. Otherwise `rx_accept` is 1 in the cycle of a busy `shift_done`.
- R5: `ovf_wr` with `ovf_wdata` = 0 clears `rx_ovf`. `ovf_wr` with `ovf_wdata` = 1 leaves it unchanged.
- R6: The transmit-side interrupt modes are as follows. Mode 7: `tx_level` reaches DEPTH. Mode 6: the shifter is busy and `tx_level` = 0. Mode 5: an accepted busy `shift_done`. Mode 4: an accepted `shift_start`.
- R7: The receive-side interrupt modes are as follows. Mode 3: `rx_level` = DEPTH. Mode 2: `rx_level` ≥ 6 (three quarters of 8). Mode 1: `rx_level` ≠ 0. Mode 0: `buf_rd` while `rx_level` = 1.
- R8: `irq` is high for exactly one cycle, on the cycle after the edge at which the selected condition first becomes true. A condition that stays true does not raise `irq` again.
- R9: A change of `mode` never raises `irq`, at the edge where the change is seen or later, unless the new mode's condition rises afterwards.
- R10: After reset, and whenever `en` = 0, every status output and `irq` read 0 and the overflow flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable |
| master | input | 1 | Selects the element-count meaning: 1 = pending, 0 = unread |
| mode | input | 3 | Interrupt condition select |
| tx_level | input | 4 | Transmit FIFO fill level, 0 to 8 |
| rx_level | input | 4 | Receive FIFO fill level, 0 to 8 |
| shift_start | input | 1 | Shifter takes a word from the transmit FIFO |
| shift_done | input | 1 | Word has fully shifted out and in |
| buf_rd | input | 1 | Software reads one receive word |
| ovf_wr | input | 1 | Software write strobe to the overflow bit |
| ovf_wdata | input | 1 | Value written to the overflow bit |
| elem_cnt | output | 3 | Saturating element count |
| sr_empty | output | 1 | Shifter idle and ready |
| rx_empty | output | 1 | Receive FIFO empty |
| tx_full | output | 1 | Transmit FIFO full |
| rx_full | output | 1 | Receive FIFO full |
| rx_ovf | output | 1 | Receive overflow flag |
| rx_accept | output | 1 | Push the arriving word into the receive FIFO |
| irq | output | 1 | One-cycle interrupt request |

## Verification
A shifter state that disagrees with the strobes appears on `sr_empty` and on the master-mode `elem_cnt` right after the edge. It also moves the mode 6 and mode 5 interrupts by a cycle or suppresses them. A stale edge-detect register or mode register shows as a missing pulse, a doubled pulse, or a spurious pulse within one cycle of a level step or a mode change. An overflow register that misses its set or its clear shows on `rx_ovf` at the next edge. The bench predicts every output every cycle from the requirements, so any of these is reported in the cycle it first appears.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_BUSY = 1'b1
    } sh_state_t;

    typedef enum logic [2:0] {
        IM_RX_DRAINED = 3'd0,
        IM_RX_AVAIL   = 3'd1,
        IM_RX_3Q      = 3'd2,
        IM_RX_FULL    = 3'd3,
        IM_TX_SLOT    = 3'd4,
        IM_TX_DONE    = 3'd5,
        IM_TX_LAST    = 3'd6,
        IM_TX_FULL    = 3'd7
    } irq_mode_t;

endpackage

// File: rtl/sbs_shift_fsm.sv
module sbs_shift_fsm
    import sbs_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             shift_start,
    input  logic             shift_done,
    input  logic [LVL_W-1:0] tx_level,
    output sh_state_t        state,
    output logic             load_evt,
    output logic             done_evt
);

    sh_state_t state_nx;
    logic      tx_avail;

    assign tx_avail = (tx_level != '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SH_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions: IDLE->BUSY on accepted start, BUSY->IDLE on done, any->IDLE when disabled
    always_comb begin
        state_nx = state;
        if (!en) begin
            state_nx = SH_IDLE;
        end else begin
            unique case (state)
                SH_IDLE: if (shift_start && tx_avail) state_nx = SH_BUSY;
                SH_BUSY: if (shift_done)              state_nx = SH_IDLE;
                default: state_nx = SH_IDLE;
            endcase
        end
    end

    // event outputs
    always_comb begin
        load_evt = 1'b0;
        done_evt = 1'b0;
        unique case (state)
            SH_IDLE: load_evt = en && shift_start && tx_avail;
            SH_BUSY: done_evt = en && shift_done;
            default: ;
        endcase
    end

endmodule

// File: rtl/sbs_flags.sv
module sbs_flags
    import sbs_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LVL_W = 4,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             master,
    input  sh_state_t        state,
    input  logic             done_evt,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             ovf_wr,
    input  logic             ovf_wdata,
    output logic [CNT_W-1:0] elem_cnt,
    output logic             sr_empty,
    output logic             rx_empty,
    output logic             tx_full,
    output logic             rx_full,
    output logic             rx_ovf,
    output logic             rx_accept
);

    localparam int SUM_W = LVL_W + 1;
    localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'((1 << CNT_W) - 1);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    logic             ovf_q;
    logic             rx_at_full;
    logic [SUM_W-1:0] raw_cnt;

    assign rx_at_full = (rx_level == FULL_LVL);

    // overflow: set by hardware on a dropped word, cleared only by a 0 write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (!en) begin
            ovf_q <= 1'b0;
        end else if (done_evt && rx_at_full) begin
            ovf_q <= 1'b1;
        end else if (ovf_wr && !ovf_wdata) begin
            ovf_q <= 1'b0;
        end
    end

    always_comb begin
        if (master) begin
            raw_cnt = {1'b0, tx_level} + SUM_W'(state == SH_BUSY);
        end else begin
            raw_cnt = {1'b0, rx_level};
        end
    end

    always_comb begin
        elem_cnt  = '0;
        sr_empty  = 1'b0;
        rx_empty  = 1'b0;
        tx_full   = 1'b0;
        rx_full   = 1'b0;
        rx_ovf    = 1'b0;
        rx_accept = 1'b0;
        if (en) begin
            elem_cnt  = (raw_cnt > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : raw_cnt[CNT_W-1:0];
            sr_empty  = (state == SH_IDLE);
            rx_empty  = (rx_level == '0);
            tx_full   = (tx_level == FULL_LVL);
            rx_full   = rx_at_full;
            rx_ovf    = ovf_q;
            rx_accept = done_evt && !rx_at_full;
        end
    end

endmodule

// File: rtl/sbs_irq_sel.sv
module sbs_irq_sel
    import sbs_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [2:0]       mode,
    input  sh_state_t        state,
    input  logic             load_evt,
    input  logic             done_evt,
    input  logic             buf_rd,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    output logic             irq
);

    localparam int N_MODES = 8;
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
    localparam logic [LVL_W-1:0] THREEQ   = LVL_W'((3 * DEPTH + 3) / 4);

    logic [N_MODES-1:0] cond_vec;
    logic [2:0]         mode_q;
    logic               cond_q;
    logic               cond;
    logic               mode_same;

    always_comb begin
        cond_vec                = '0;
        cond_vec[IM_TX_FULL]    = (tx_level == FULL_LVL);
        cond_vec[IM_TX_LAST]    = (state == SH_BUSY) && (tx_level == '0);
        cond_vec[IM_TX_DONE]    = done_evt;
        cond_vec[IM_TX_SLOT]    = load_evt;
        cond_vec[IM_RX_FULL]    = (rx_level == FULL_LVL);
        cond_vec[IM_RX_3Q]      = (rx_level >= THREEQ);
        cond_vec[IM_RX_AVAIL]   = (rx_level != '0);
        cond_vec[IM_RX_DRAINED] = buf_rd && (rx_level == LVL_W'(1));
    end

    assign cond      = cond_vec[mode];
    assign mode_same = (mode == mode_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 3'd0;
            cond_q <= 1'b0;
            irq    <= 1'b0;
        end else begin
            mode_q <= mode;
            cond_q <= en && cond;
            irq    <= en && mode_same && cond && !cond_q;
        end
    end

endmodule

// File: rtl/spi_buf_status_irq.sv
module spi_buf_status_irq
    import sbs_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = 3,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             master,
    input  logic [2:0]       mode,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             shift_start,
    input  logic             shift_done,
    input  logic             buf_rd,
    input  logic             ovf_wr,
    input  logic             ovf_wdata,
    output logic [CNT_W-1:0] elem_cnt,
    output logic             sr_empty,
    output logic             rx_empty,
    output logic             tx_full,
    output logic             rx_full,
    output logic             rx_ovf,
    output logic             rx_accept,
    output logic             irq
);

    sh_state_t sh_state;
    logic      load_evt;
    logic      done_evt;

    sbs_shift_fsm #(.LVL_W(LVL_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .shift_start (shift_start),
        .shift_done  (shift_done),
        .tx_level    (tx_level),
        .state       (sh_state),
        .load_evt    (load_evt),
        .done_evt    (done_evt)
    );

    sbs_flags #(.DEPTH(DEPTH), .LVL_W(LVL_W), .CNT_W(CNT_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .master    (master),
        .state     (sh_state),
        .done_evt  (done_evt),
        .tx_level  (tx_level),
        .rx_level  (rx_level),
        .ovf_wr    (ovf_wr),
        .ovf_wdata (ovf_wdata),
        .elem_cnt  (elem_cnt),
        .sr_empty  (sr_empty),
        .rx_empty  (rx_empty),
        .tx_full   (tx_full),
        .rx_full   (rx_full),
        .rx_ovf    (rx_ovf),
        .rx_accept (rx_accept)
    );

    sbs_irq_sel #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .mode     (mode),
        .state    (sh_state),
        .load_evt (load_evt),
        .done_evt (done_evt),
        .buf_rd   (buf_rd),
        .tx_level (tx_level),
        .rx_level (rx_level),
        .irq      (irq)
    );

endmodule

// File: rtl/spi_buf_status_irq_chk.sv
module spi_buf_status_irq_chk #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 3,
    parameter int LVL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [2:0]       mode,
    input logic [LVL_W-1:0] rx_level,
    input logic             shift_start,
    input logic             shift_done,
    input logic             ovf_wr,
    input logic             ovf_wdata,
    input logic [CNT_W-1:0] elem_cnt,
    input logic             sr_empty,
    input logic             rx_full,
    input logic             rx_ovf,
    input logic             rx_accept,
    input logic             irq
);

    // R1: shifter leaves idle only on a start strobe
    p_busy_needs_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sr_empty && !shift_start) |=> (!en || sr_empty));

    // R4: busy done with a full receive FIFO sets the overflow flag
    p_ovf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !sr_empty && shift_done && rx_level == LVL_W'(DEPTH)) |=> (rx_ovf || !en));

    // R4: a word is never pushed into a full receive FIFO
    p_no_push_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_accept |-> !rx_full);

    // R5: writing 1 leaves a set overflow flag set
    p_ovf_w1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rx_ovf && ovf_wr && ovf_wdata) |=> (rx_ovf || !en));

    // R8: the interrupt is a single-cycle pulse
    p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R9: a mode change does not raise the interrupt
    p_mode_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != $past(mode)) |=> !irq);

    // R10: disabled block shows nothing
    p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (elem_cnt == '0 && !sr_empty && !rx_ovf && !rx_accept));

    p_disabled_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !irq);

endmodule

bind spi_buf_status_irq spi_buf_status_irq_chk #(
    .DEPTH(DEPTH), .CNT_W(CNT_W), .LVL_W(LVL_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .mode        (mode),
    .rx_level    (rx_level),
    .shift_start (shift_start),
    .shift_done  (shift_done),
    .ovf_wr      (ovf_wr),
    .ovf_wdata   (ovf_wdata),
    .elem_cnt    (elem_cnt),
    .sr_empty    (sr_empty),
    .rx_full     (rx_full),
    .rx_ovf      (rx_ovf),
    .rx_accept   (rx_accept),
    .irq         (irq)
);

// File: tb/spi_buf_status_irq_test.sv
`timescale 1ns/1ps
module spi_buf_status_irq_test;

    localparam int DEPTH = 8;
    localparam int LVL_W = 4;
    localparam int CNT_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0, master = 1'b0;
    logic [2:0]       mode = 3'd0;
    logic [LVL_W-1:0] txl = '0, rxl = '0;
    logic             ss = 1'b0, sd = 1'b0, rd = 1'b0, ow = 1'b0, owd = 1'b0;
    logic [CNT_W-1:0] elem_cnt;
    logic             sr_empty, rx_empty, tx_full, rx_full, rx_ovf, rx_accept, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    spi_buf_status_irq uut (
        .clk(clk), .rst_n(rst_n), .en(en), .master(master), .mode(mode),
        .tx_level(txl), .rx_level(rxl), .shift_start(ss), .shift_done(sd),
        .buf_rd(rd), .ovf_wr(ow), .ovf_wdata(owd),
        .elem_cnt(elem_cnt), .sr_empty(sr_empty), .rx_empty(rx_empty),
        .tx_full(tx_full), .rx_full(rx_full), .rx_ovf(rx_ovf),
        .rx_accept(rx_accept), .irq(irq)
    );

    // reference state kept from the requirements
    bit       m_busy = 0, m_ovf = 0, m_pcond = 0;
    bit [2:0] m_pmode = 0;

    // scoreboard: one packed expectation per cycle plus its requirement tag
    // {irq, cnt[2:0], sr_empty, rx_empty, tx_full, rx_full, rx_ovf}
    logic [8:0] q_exp[$];
    string      q_req[$];

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // driver: predict the post-edge outputs, queue them, advance one cycle
    task automatic tick(string irq_req);
        bit cond, irq_n, busy_n, ovf_n, dn, ld;
        int cnt;
        logic [8:0] e;
        #1;
        ld = en && !m_busy && ss && (txl != 0);
        dn = en && m_busy && sd;
        chk("R4 rx_accept", rx_accept, (dn && rxl != DEPTH) ? 1 : 0);
        case (mode)
            3'd7: cond = (txl == DEPTH);
            3'd6: cond = m_busy && (txl == 0);
            3'd5: cond = dn;
            3'd4: cond = ld;
            3'd3: cond = (rxl == DEPTH);
            3'd2: cond = (rxl >= 6);
            3'd1: cond = (rxl != 0);
            default: cond = rd && (rxl == 1);
        endcase
        irq_n   = en && (mode == m_pmode) && cond && !m_pcond;
        m_pcond = en && cond;
        m_pmode = mode;
        if (!en)     busy_n = 0;
        else if (ld) busy_n = 1;
        else if (dn) busy_n = 0;
        else         busy_n = m_busy;
        if (!en)                      ovf_n = 0;
        else if (dn && rxl == DEPTH)  ovf_n = 1;
        else if (ow && !owd)          ovf_n = 0;
        else                          ovf_n = m_ovf;
        m_busy = busy_n;
        m_ovf  = ovf_n;
        cnt = master ? (int'(txl) + int'(busy_n)) : int'(rxl);
        if (cnt > 7) cnt = 7;
        if (en) e = {irq_n, 3'(cnt), !busy_n, rxl == 0, txl == DEPTH, rxl == DEPTH, ovf_n};
        else    e = {irq_n, 8'd0};
        q_exp.push_back(e);
        q_req.push_back(irq_req);
        @(negedge clk);
    endtask

    // monitor: compare after each edge while expectations are queued
    always @(posedge clk) begin
        #1;
        if (q_exp.size() > 0) begin
            logic [8:0] e;
            string r;
            e = q_exp.pop_front();
            r = q_req.pop_front();
            chk(r,             irq,      e[8]);
            chk("R3 elem_cnt", elem_cnt, e[7:5]);
            chk("R1 sr_empty", sr_empty, e[4]);
            chk("R2 rx_empty", rx_empty, e[3]);
            chk("R2 tx_full",  tx_full,  e[2]);
            chk("R2 rx_full",  rx_full,  e[1]);
            chk("R4/R5 rx_ovf", rx_ovf,  e[0]);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 reset irq", irq, 0);
        chk("R10 reset sr_empty", sr_empty, 0);
        chk("R10 reset rx_ovf", rx_ovf, 0);
        rst_n = 1'b1;
        @(negedge clk);
        tick("R10"); tick("R10");

        // R7 mode 1 and R8 single pulse
        en = 1; mode = 3'd1;
        tick("R9"); tick("R7");
        rxl = 1; tick("R7 mode1");
        rxl = 2; tick("R8"); tick("R8");
        // R9 mode switch while both conditions hold
        rxl = 8; tick("R8");
        mode = 3'd3; tick("R9"); tick("R9");
        rxl = 7; tick("R7");
        rxl = 8; tick("R7 mode3");
        // R7 mode 2
        mode = 3'd2; rxl = 5; tick("R9"); tick("R7");
        rxl = 6; tick("R7 mode2");
        rxl = 7; tick("R8");
        // R7 mode 0
        mode = 3'd0; rxl = 1; tick("R9");
        rd = 1; tick("R7 mode0");
        rd = 0; rxl = 0; tick("R8");
        // R6 mode 7 and R3 saturation
        mode = 3'd7; txl = 7; tick("R9");
        txl = 8; tick("R6 mode7"); tick("R8");
        master = 1; tick("R3");
        // R1 start with empty FIFO ignored
        mode = 3'd4; txl = 0; ss = 1; tick("R1");
        // R6 mode 4
        txl = 3; tick("R6 mode4");
        ss = 0; tick("R1");
        // R6 mode 6
        mode = 3'd6; tick("R9");
        txl = 1; tick("R6");
        txl = 0; tick("R6 mode6"); tick("R8");
        // R6 mode 5
        mode = 3'd5; tick("R9");
        sd = 1; tick("R6 mode5");
        sd = 0; tick("R1");
        // R4 overflow and R5 clear rules
        master = 0; mode = 3'd1; rxl = 8; txl = 2; tick("R9");
        ss = 1; tick("R1");
        ss = 0; sd = 1; tick("R4 drop");
        sd = 0; tick("R4");
        ow = 1; owd = 1; tick("R5 write1");
        owd = 0; tick("R5 write0");
        ow = 0; tick("R5");
        // R4 accepted word
        ss = 1; tick("R1");
        ss = 0; rxl = 4; sd = 1; tick("R4 accept");
        sd = 0; tick("R4");
        // R10 disable clears a set overflow
        rxl = 8; ss = 1; tick("R1");
        ss = 0; sd = 1; tick("R4");
        sd = 0; en = 0; tick("R10"); tick("R10");
        en = 1; mode = 3'd3; tick("R10");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule